// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether an incoming destination MAC address should be kept. The address arrives as six bytes, one per accepted cycle, with byte 0 first. A start strobe that comes with byte 0 marks the beginning of an address. While the bytes stream in, the block runs a reflected CRC-32 over them one bit at a time. Inside each byte it takes the least significant bit first.

Once the last byte has been taken, the six most significant CRC bits form an index from 0 to 63. The index picks one bit of a 64-bit individual-address hash table, which is held as two 32-bit words. In parallel the block compares the address for equality against a programmed station address. Software loads the station address and the hash table through two plain write ports. The block then reports hash hit, exact hit and accept, registered, one cycle after the sixth byte.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset `resultValid`, `acceptOut`, `exactHit` and `hashHit` are all 0.
- R2: The CRC starts at 0xFFFFFFFF. Bytes are folded in order 0 to 5 and each byte least significant bit first. For each bit the CRC shifts right by one, and it is XORed with 0xEDB88320 when the input bit differs from the old CRC bit 0. The hash index is bits 31..26 of the final CRC.
- R3: An index of 32 or more selects bit (index-32) of table word 1 (`hashWrSel`=1). A smaller index selects bit index of table word 0 (`hashWrSel`=0). `hashHit` equals the selected bit.
- R4: Station word 0 (`stationWrSel`=0) holds bytes 0..3, with byte 0 in bits 31..24. Station word 1 holds byte 4 in bits 31..24 and byte 5 in bits 23..16. Bits 15..0 of word 1 have no effect. `exactHit` is 1 only when all 48 address bits are equal to the station address.
- R5: `acceptOut` is 1 exactly when `exactHit` or `hashHit` is 1.
- R6: The result appears on the cycle after the clock edge that takes byte 5. `resultValid` is a one-cycle pulse, and all three flags read 0 whenever `resultValid` is 0.
- R7: A start strobe with `byteValid` reloads the CRC to all ones and begins a new address. A partly received address is then dropped without a result.
- R8: Cycles with `byteValid` low pause the address without losing any state. Bytes offered without a start while no address is open are ignored and produce no result.
- R9: A new address may start on the very cycle in which the previous result is shown, and both results are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stationWrEn | input | 1 | Write strobe for a station address word |
| stationWrSel | input | 1 | Station word select (0: bytes 0..3, 1: bytes 4..5 in upper half) |
| stationWrData | input | 32 | Station word write data |
| hashWrEn | input | 1 | Write strobe for a hash table word |
| hashWrSel | input | 1 | Hash table word select (0: indices 0..31, 1: indices 32..63) |
| hashWrData | input | 32 | Hash table word write data |
| startIn | input | 1 | Marks byte 0 of a new address (qualified by byteValid) |
| byteValid | input | 1 | Address byte present on byteIn |
| byteIn | input | 8 | Address byte |
| resultValid | output | 1 | One-cycle pulse: flags below are valid |
| acceptOut | output | 1 | Address accepted (exact or hash) |
| exactHit | output | 1 | Address equals station address |
| hashHit | output | 1 | Selected hash table bit is set |

## Verification
The hardest case to reach from the ports is a hash hit on a chosen table bit. With random addresses only about one in 64 lands on a given bit, so most bits would never be checked. To get there, the bench computes the index of candidate addresses on its own and searches for one that maps to each of the 64 indices. It then sets only that bit. To catch a wrong word select, it also sets only the same bit position in the other word. Aborted addresses, stalled bytes and back-to-back addresses are driven directly, so that restart and pause behaviour is seen on the result pulse.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

  localparam int ADDR_BYTES  = 6;
  localparam int ADDR_W      = 8 * ADDR_BYTES;
  localparam int CRC_W       = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;
  localparam int HASH_BITS   = 6;
  localparam int WORD_W      = 32;
  localparam int TABLE_BITS  = 2 ** HASH_BITS;
  localparam int TABLE_WORDS = TABLE_BITS / WORD_W;
  localparam int TSEL_W      = (TABLE_WORDS > 1) ? $clog2(TABLE_WORDS) : 1;
  localparam int SLOT_W      = $clog2(ADDR_BYTES);
  localparam int STATION_HI_W = ADDR_W - WORD_W;

  // Strobes from the byte sequencer to the datapath
  typedef struct packed {
    logic              seed;    // byte 0 of a new address: start from CRC_SEED
    logic              shift;   // a byte is taken this cycle
    logic              finish;  // the byte taken is the last one
    logic [SLOT_W-1:0] slot;    // position of the byte being taken
  } filterStrobes_t;

  // One byte through the reflected CRC, least significant bit first
  function automatic logic [CRC_W-1:0] crcByteStep(input logic [CRC_W-1:0] crcIn,
                                                   input logic [7:0] dataIn);
    logic [CRC_W-1:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dataIn[i]) c = (c >> 1) ^ CRC_POLY;
      else                  c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           startIn,
  input  logic           byteValid,
  output filterStrobes_t strobes
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(ADDR_BYTES - 1);

  logic              busy;
  logic [SLOT_W-1:0] byteCnt;
  logic              takeByte;

  always_comb begin
    takeByte       = byteValid && (startIn || busy);
    strobes.seed   = byteValid && startIn;
    strobes.shift  = takeByte;
    strobes.slot   = startIn ? '0 : byteCnt;
    strobes.finish = takeByte && !startIn && (byteCnt == LAST_SLOT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      byteCnt <= '0;
    end else if (strobes.seed) begin
      busy    <= 1'b1;
      byteCnt <= SLOT_W'(1);
    end else if (takeByte) begin
      if (strobes.finish) begin
        busy    <= 1'b0;
        byteCnt <= '0;
      end else begin
        byteCnt <= byteCnt + SLOT_W'(1);
      end
    end
  end

  // R8: a result can only close an address that was opened by a start
  a_r8_finish_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |-> busy);

  // R7: a start always reopens at the second byte position
  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && startIn) |=> (busy && byteCnt == SLOT_W'(1)));

  // R6: the sequencer is closed right after the last byte
  a_r6_closed_after_last: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !busy);

  // R8: counter never runs past the address length
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_SLOT);

endmodule

// File: rtl/addr_filter_datapath.sv
module addr_filter_datapath
  import addr_filter_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                stationWrEn,
  input  logic                stationWrSel,
  input  logic [WORD_W-1:0]   stationWrData,
  input  logic                hashWrEn,
  input  logic [TSEL_W-1:0]   hashWrSel,
  input  logic [WORD_W-1:0]   hashWrData,
  input  logic [7:0]          byteIn,
  input  filterStrobes_t      strobes,
  output logic                resultValid,
  output logic                acceptOut,
  output logic                exactHit,
  output logic                hashHit
);

  logic [WORD_W-1:0]       stationLo;
  logic [STATION_HI_W-1:0] stationHi;
  logic [WORD_W-1:0]       hashTable [TABLE_WORDS];
  logic [CRC_W-1:0]        crcReg;
  logic [7:0]              addrBuf [ADDR_BYTES];

  logic [CRC_W-1:0]        crcBase;
  logic [CRC_W-1:0]        crcStep;
  logic [HASH_BITS-1:0]    hashIdx;
  logic [TABLE_BITS-1:0]   tableFlat;
  logic [ADDR_W-1:0]       liveAddr;
  logic                    exactNow;
  logic                    hashNow;

  // Register programming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stationLo <= '0;
      stationHi <= '0;
    end else if (stationWrEn) begin
      if (stationWrSel) stationHi <= stationWrData[WORD_W-1 -: STATION_HI_W];
      else              stationLo <= stationWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < TABLE_WORDS; w++) hashTable[w] <= '0;
    end else if (hashWrEn) begin
      hashTable[hashWrSel] <= hashWrData;
    end
  end

  // CRC accumulation and address capture
  always_comb begin
    crcBase = strobes.seed ? CRC_SEED : crcReg;
    crcStep = crcByteStep(crcBase, byteIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= CRC_SEED;
      for (int b = 0; b < ADDR_BYTES; b++) addrBuf[b] <= '0;
    end else if (strobes.shift) begin
      crcReg                 <= crcStep;
      addrBuf[strobes.slot]  <= byteIn;
    end
  end

  // Decision on the last byte: earlier bytes from the buffer, last one live
  generate
    for (genvar g = 0; g < TABLE_WORDS; g++) begin : g_flat
      assign tableFlat[g*WORD_W +: WORD_W] = hashTable[g];
    end
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
      if (g == ADDR_BYTES - 1) begin : g_live
        assign liveAddr[8*(ADDR_BYTES-1-g) +: 8] = byteIn;
      end else begin : g_held
        assign liveAddr[8*(ADDR_BYTES-1-g) +: 8] = addrBuf[g];
      end
    end
  endgenerate

  always_comb begin
    hashIdx  = crcStep[CRC_W-1 -: HASH_BITS];
    hashNow  = tableFlat[hashIdx];
    exactNow = (liveAddr == {stationLo, stationHi});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      acceptOut   <= 1'b0;
      exactHit    <= 1'b0;
      hashHit     <= 1'b0;
    end else begin
      resultValid <= strobes.finish;
      exactHit    <= strobes.finish && exactNow;
      hashHit     <= strobes.finish && hashNow;
      acceptOut   <= strobes.finish && (exactNow || hashNow);
    end
  end

  // R6: the result is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6: flags stay quiet outside the result cycle
  a_r6_flags_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> !(acceptOut || exactHit || hashHit));

  // R5: accept agrees with the two match flags
  a_r5_accept_is_or: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (acceptOut == (exactHit || hashHit)));

  // R6: a result follows exactly the cycle that closed the address
  a_r6_result_follows_finish: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> resultValid);

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stationWrEn,
  input  logic              stationWrSel,
  input  logic [31:0]       stationWrData,
  input  logic              hashWrEn,
  input  logic              hashWrSel,
  input  logic [31:0]       hashWrData,
  input  logic              startIn,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  output logic              resultValid,
  output logic              acceptOut,
  output logic              exactHit,
  output logic              hashHit
);

  filterStrobes_t strobes;

  addr_filter_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .byteValid (byteValid),
    .strobes   (strobes)
  );

  addr_filter_datapath i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .stationWrEn   (stationWrEn),
    .stationWrSel  (stationWrSel),
    .stationWrData (stationWrData),
    .hashWrEn      (hashWrEn),
    .hashWrSel     (TSEL_W'(hashWrSel)),
    .hashWrData    (hashWrData),
    .byteIn        (byteIn),
    .strobes       (strobes),
    .resultValid   (resultValid),
    .acceptOut     (acceptOut),
    .exactHit      (exactHit),
    .hashHit       (hashHit)
  );

endmodule

// File: tb/test_dest_addr_filter.sv
module test_dest_addr_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stationWrEn = 1'b0;
  logic        stationWrSel = 1'b0;
  logic [31:0] stationWrData = '0;
  logic        hashWrEn = 1'b0;
  logic        hashWrSel = 1'b0;
  logic [31:0] hashWrData = '0;
  logic        startIn = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        resultValid, acceptOut, exactHit, hashHit;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter i_dest_addr_filter (
    .clk(clk), .rstN(rstN),
    .stationWrEn(stationWrEn), .stationWrSel(stationWrSel), .stationWrData(stationWrData),
    .hashWrEn(hashWrEn), .hashWrSel(hashWrSel), .hashWrData(hashWrData),
    .startIn(startIn), .byteValid(byteValid), .byteIn(byteIn),
    .resultValid(resultValid), .acceptOut(acceptOut), .exactHit(exactHit), .hashHit(hashHit)
  );

  // Index per the CRC rule: seed ones, reflected poly, byte 0 first, LSB first
  function automatic logic [5:0] expIdx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  d;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      d = a[47 - 8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        if (c[0] != d[i]) c = (c >> 1) ^ 32'hEDB88320;
        else              c = c >> 1;
      end
    end
    return c[31:26];
  endfunction

  task automatic writeStation(input logic [47:0] a, input logic [15:0] junk);
    stationWrEn = 1'b1; stationWrSel = 1'b0; stationWrData = a[47:16];
    @(negedge clk);
    stationWrSel = 1'b1; stationWrData = {a[15:0], junk};
    @(negedge clk);
    stationWrEn = 1'b0;
  endtask

  task automatic writeHash(input logic [31:0] lo, input logic [31:0] hi);
    hashWrEn = 1'b1; hashWrSel = 1'b0; hashWrData = lo;
    @(negedge clk);
    hashWrSel = 1'b1; hashWrData = hi;
    @(negedge clk);
    hashWrEn = 1'b0;
  endtask

  task automatic setIndexBit(input int k);
    writeHash((k < 32) ? (32'd1 << k) : 32'd0, (k >= 32) ? (32'd1 << (k - 32)) : 32'd0);
  endtask

  // Leaves the bench at the negedge where the result is visible
  task automatic sendAddr(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      startIn = (i == 0); byteValid = 1'b1; byteIn = a[47 - 8*i -: 8];
      @(negedge clk);
      if (gap > 0 && i < 5) begin
        startIn = 1'b0; byteValid = 1'b0; byteIn = 8'hA5;
        repeat (gap) @(negedge clk);
      end
    end
    startIn = 1'b0; byteValid = 1'b0;
  endtask

  task automatic sendPartial(input logic [47:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      startIn = (i == 0); byteValid = 1'b1; byteIn = a[47 - 8*i -: 8];
      @(negedge clk);
      testCount++;
      if (resultValid !== 1'b0) begin
        failCount++;
        $display("FAIL R7 partial address gave result: actual=%b expected=0", resultValid);
      end
    end
    startIn = 1'b0; byteValid = 1'b0;
  endtask

  task automatic checkResult(input string req, input logic ex, input logic hs);
    logic [3:0] act, expv;
    act  = {resultValid, acceptOut, exactHit, hashHit};
    expv = {1'b1, ex | hs, ex, hs};
    testCount++;
    if (act !== expv) begin
      failCount++;
      $display("FAIL %s valid/accept/exact/hash: actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic checkIdle(input string req);
    logic [3:0] act;
    act = {resultValid, acceptOut, exactHit, hashHit};
    testCount++;
    if (act !== 4'b0000) begin
      failCount++;
      $display("FAIL %s idle outputs: actual=%b expected=0000", req, act);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [47:0] stA, stB, cand, other;
    logic [5:0]  idx;
    logic        found;

    // R1: reset state
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // R2/R3: every index, matching and non-matching, plus the wrong word
    writeStation(48'hFFFF_FFFF_FFFF, 16'h0000);
    for (int k = 0; k < 64; k++) begin
      found = 1'b0; cand = '0; other = '0;
      for (int s = 1; s < 8192 && !found; s++) begin
        cand = 48'h0200_0000_0000 ^ (48'(s) * 48'h0001_9E37_79B1);
        if (expIdx(cand) == 6'(k)) found = 1'b1;
      end
      other = cand ^ 48'h0000_0000_0001;
      if (expIdx(other) == 6'(k)) other = cand ^ 48'h0000_0000_0100;
      setIndexBit(k);
      sendAddr(cand, 0);
      checkResult("R2 R3 hit", 1'b0, found);
      sendAddr(other, 0);
      checkResult("R2 R3 miss", 1'b0, expIdx(other) == 6'(k));
      setIndexBit(k ^ 32);
      sendAddr(cand, 0);
      checkResult("R3 word select", 1'b0, 1'b0);
    end

    // R4: exact match and every single-bit difference
    writeHash(32'h0, 32'h0);
    stA = 48'h00_1B_44_11_3A_B7;
    writeStation(stA, 16'hBEEF);
    sendAddr(stA, 0);
    checkResult("R4 exact", 1'b1, 1'b0);
    for (int b = 0; b < 48; b++) begin
      sendAddr(stA ^ (48'd1 << b), 0);
      checkResult("R4 one bit off", 1'b0, 1'b0);
    end
    stationWrEn = 1'b1; stationWrSel = 1'b1; stationWrData = {stA[15:0], 16'h1234};
    @(negedge clk);
    stationWrEn = 1'b0;
    sendAddr(stA, 0);
    checkResult("R4 low half ignored", 1'b1, 1'b0);

    // R5: both flags at once
    idx = expIdx(stA);
    setIndexBit(int'(idx));
    sendAddr(stA, 0);
    checkResult("R5 both", 1'b1, 1'b1);
    writeHash(32'h0, 32'h0);

    // R6: pulse is one cycle wide
    @(negedge clk);
    checkIdle("R6");

    // R8: stalls between bytes
    sendAddr(stA, 3);
    checkResult("R8 gaps", 1'b1, 1'b0);
    // R8: stray bytes with no start produce nothing
    byteValid = 1'b1; startIn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      byteIn = 8'(i);
      @(negedge clk);
      checkIdle("R8 stray");
    end
    byteValid = 1'b0;
    sendAddr(stA, 0);
    checkResult("R8 after stray", 1'b1, 1'b0);

    // R7: restart mid-address; the abandoned one would have matched
    stB = 48'h5E_00_53_AA_01_02;
    sendPartial(stA, 5);
    sendAddr(stB, 0);
    checkResult("R7 restart", 1'b0, 1'b0);
    writeStation(stB, 16'h0);
    sendPartial(stA, 3);
    sendAddr(stB, 1);
    checkResult("R7 restart match", 1'b1, 1'b0);

    // R9: back-to-back addresses
    setIndexBit(int'(expIdx(stA)));
    sendAddr(stA, 0);
    checkResult("R9 first", 1'b0, 1'b1);
    sendAddr(stB, 0);
    checkResult("R9 second", 1'b1, expIdx(stB) == expIdx(stA));
    @(negedge clk);
    checkIdle("R6 after back-to-back");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule